// File: doc/BRIEF.md
# Thirty-Two Pin GPIO Controller with Edge Events

This block is a general-purpose I/O controller for thirty-two pins, reached through a simple synchronous register bus. Software decides pin by pin whether a pin is driven or sampled. It writes the levels for the driven pins and reads back a data word that combines the driven levels with the sampled inputs. Each input pin can flag an event when its level changes. A per-pin control bit selects whether any change counts or only a high-to-low transition. Event bits stay set until software clears them by writing ones. A single level-sensitive interrupt is high while any event bit is also enabled in the mask.

Input pins pass through a two-flop synchronizer. A third flop holds the previous synchronized value, and edges are found by comparing the two. Register bits are numbered opposite to pins: pin n occupies register bit 31-n. The open-drain register is plain storage for software and has no effect on the pins.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: Six word registers sit at these byte offsets: 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask, 0x14 control. A read with `bus_rd` and `bus_word` high shows the register value on `bus_rdata` in the following cycle. In every other cycle `bus_rdata` is zero.
- R2: An access with `bus_word` low returns zero on a read and changes nothing on a write. An offset outside the six listed reads as zero and ignores writes.
- R3: Pin n (index n of `pin_in`, `pin_out` and `pin_dir`) corresponds to register bit 31-n, so pin 0 is register bit 31.
- R4: A direction bit of 1 makes its pin an output. `pin_dir` mirrors the direction register. `pin_out` carries the written data bit for output pins and 0 for input pins. Output pins never set event bits.
- R5: Reading the data register returns the last written data bit for output pins and the synchronized sample for input pins.
- R6: A write to the event register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: `irq` is high exactly when some bit of (event AND mask) is 1.
- R8: With its control bit at 0, an input pin sets its event bit on any change of level.
- R9: With its control bit at 1, an input pin sets its event bit only on a high-to-low transition. A rising edge sets nothing.
- R10: Reset clears all six registers. Every pin is then an input, `pin_out` is zero and `irq` is low.
- R11: When an input event and a clearing write reach the same event bit in the same cycle, the bit ends at 1.
- R12: The open-drain register reads back what was written and has no effect on `pin_out` or `pin_dir`.
- R13: A level change on an input pin appears in the data register after the second rising clock edge. It sets the event bit, and `irq` if enabled, at the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 1 | High for a full 32-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| pin_in | input | 32 | Pin levels, indexed by pin number |
| pin_out | output | 32 | Driven pin levels, indexed by pin number |
| pin_dir | output | 32 | Output enable per pin, indexed by pin number |
| irq | output | 1 | Level interrupt |

## Verification
The bench toggles an input pin on the least significant register bit and a pin on bit 31. A design with the bit order flipped would drive pin 31 from the top data bit and report events in the wrong bit. It checks the falling-only control mode with a rising edge first; a design with the comparison inverted would flag the rise and stay silent on the fall. It lands a clearing write in exactly the cycle an event is set, where a design that gave the clear priority would lose the event. It counts the edges from a pin change to `irq`, which exposes a missing or extra synchronizer stage. It also issues narrow and unmapped accesses, which a design decoding too loosely would let corrupt the direction register.

// File: rtl/gpio_evt_pkg.sv
`timescale 1ns/1ps
package gpio_evt_pkg;

    localparam int unsigned REG_W = 32;

    localparam int unsigned OFF_DIR = 'h00;
    localparam int unsigned OFF_ODR = 'h04;
    localparam int unsigned OFF_DAT = 'h08;
    localparam int unsigned OFF_EVT = 'h0C;
    localparam int unsigned OFF_MSK = 'h10;
    localparam int unsigned OFF_CTL = 'h14;

    typedef enum logic [2:0] {
        SEL_DIR,
        SEL_ODR,
        SEL_DAT,
        SEL_EVT,
        SEL_MSK,
        SEL_CTL,
        SEL_NONE
    } gpio_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] dir;
        logic [REG_W-1:0] odr;
        logic [REG_W-1:0] dout;
        logic [REG_W-1:0] evt;
        logic [REG_W-1:0] msk;
        logic [REG_W-1:0] ctl;
        logic [REG_W-1:0] rdat;
    } gpio_state_t;

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] smp,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = din;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign smp  = sy_q.s2;
    assign prev = sy_q.s3;
endmodule

// File: rtl/gpio_edge_sel.sv
`timescale 1ns/1ps
module gpio_edge_sel #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] smp,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] ctl,
    input  logic [W-1:0] dir,
    output logic [W-1:0] hit
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        // control 1: falling only; control 0: any change; outputs never hit
        assign hit[b] = ~dir[b] & (ctl[b] ? (prev[b] & ~smp[b])
                                          : (prev[b] ^ smp[b]));
    end
endmodule

// File: rtl/gpio_rd_mux.sv
`timescale 1ns/1ps
module gpio_rd_mux
    import gpio_evt_pkg::*;
(
    input  gpio_sel_e        sel,
    input  logic [REG_W-1:0] dir,
    input  logic [REG_W-1:0] odr,
    input  logic [REG_W-1:0] dout,
    input  logic [REG_W-1:0] evt,
    input  logic [REG_W-1:0] msk,
    input  logic [REG_W-1:0] ctl,
    input  logic [REG_W-1:0] smp,
    output logic [REG_W-1:0] val
);
    always_comb begin
        unique case (sel)
            SEL_DIR: val = dir;
            SEL_ODR: val = odr;
            SEL_DAT: val = (dout & dir) | (smp & ~dir);
            SEL_EVT: val = evt;
            SEL_MSK: val = msk;
            SEL_CTL: val = ctl;
            default: val = '0;
        endcase
    end
endmodule

// File: rtl/gpio_evt_ctrl.sv
`timescale 1ns/1ps
module gpio_evt_ctrl
    import gpio_evt_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_word,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [REG_W-1:0]  pin_in,
    output logic [REG_W-1:0]  pin_out,
    output logic [REG_W-1:0]  pin_dir,
    output logic              irq
);
    gpio_state_t st_d, st_q;

    logic [REG_W-1:0] in_reg;
    logic [REG_W-1:0] out_reg;
    logic [REG_W-1:0] smp;
    logic [REG_W-1:0] prev;
    logic [REG_W-1:0] hit;
    logic [REG_W-1:0] rd_val;
    logic [REG_W-1:0] clr;
    gpio_sel_e        sel;

    // pin n <-> register bit REG_W-1-n
    for (genvar n = 0; n < REG_W; n++) begin : g_map
        assign in_reg[REG_W-1-n] = pin_in[n];
        assign pin_out[n]        = out_reg[REG_W-1-n];
        assign pin_dir[n]        = st_q.dir[REG_W-1-n];
    end

    assign out_reg = st_q.dout & st_q.dir;

    always_comb begin
        if      (bus_addr == ADDR_W'(OFF_DIR)) sel = SEL_DIR;
        else if (bus_addr == ADDR_W'(OFF_ODR)) sel = SEL_ODR;
        else if (bus_addr == ADDR_W'(OFF_DAT)) sel = SEL_DAT;
        else if (bus_addr == ADDR_W'(OFF_EVT)) sel = SEL_EVT;
        else if (bus_addr == ADDR_W'(OFF_MSK)) sel = SEL_MSK;
        else if (bus_addr == ADDR_W'(OFF_CTL)) sel = SEL_CTL;
        else                                   sel = SEL_NONE;
    end

    gpio_in_sync #(.W(REG_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (in_reg),
        .smp  (smp),
        .prev (prev)
    );

    gpio_edge_sel #(.W(REG_W)) u_edge (
        .smp (smp),
        .prev(prev),
        .ctl (st_q.ctl),
        .dir (st_q.dir),
        .hit (hit)
    );

    gpio_rd_mux u_rmux (
        .sel (sel),
        .dir (st_q.dir),
        .odr (st_q.odr),
        .dout(st_q.dout),
        .evt (st_q.evt),
        .msk (st_q.msk),
        .ctl (st_q.ctl),
        .smp (smp),
        .val (rd_val)
    );

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (bus_wr && bus_word) begin
            unique case (sel)
                SEL_DIR: st_d.dir  = bus_wdata;
                SEL_ODR: st_d.odr  = bus_wdata;
                SEL_DAT: st_d.dout = bus_wdata;
                SEL_EVT: clr       = bus_wdata;
                SEL_MSK: st_d.msk  = bus_wdata;
                SEL_CTL: st_d.ctl  = bus_wdata;
                default: ;
            endcase
        end
        // hardware set wins over a same-cycle clear
        st_d.evt  = (st_q.evt & ~clr) | hit;
        st_d.rdat = (bus_rd && bus_word) ? rd_val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdat;
    assign irq       = |(st_q.evt & st_q.msk);
endmodule

// File: rtl/gpio_evt_chk.sv
`timescale 1ns/1ps
module gpio_evt_chk
    import gpio_evt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             bus_word,
    input logic [REG_W-1:0] bus_rdata,
    input logic [REG_W-1:0] pin_out,
    input logic [REG_W-1:0] pin_dir,
    input logic             irq,
    input logic [REG_W-1:0] evt,
    input logic [REG_W-1:0] dir
);
    p_idle_rdata_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    p_narrow_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_word) |=> (bus_rdata == '0));

    p_narrow_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_word) |=> ($stable(pin_dir) && $stable(pin_out)));

    p_pins_hold_without_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_word) |=> ($stable(pin_out) && $stable(pin_dir)));

    p_no_event_on_output_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt & ~$past(evt) & $past(dir)) == '0));

    p_irq_drop_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_wr && bus_word));
endmodule

bind gpio_evt_ctrl gpio_evt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_word (bus_word),
    .bus_rdata(bus_rdata),
    .pin_out  (pin_out),
    .pin_dir  (pin_dir),
    .irq      (irq),
    .evt      (st_q.evt),
    .dir      (st_q.dir)
);

// File: tb/gpio_evt_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_evt_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_word = 1'b1;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_dir;
    logic        irq;

    int  vectors = 0;
    int  miscompares = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    gpio_evt_ctrl u_gpio_evt_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_word(bus_word), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_dir(pin_dir), .irq(irq)
    );

    // reference model, register-bit order (pin n = bit 31-n)
    logic [31:0] m_dir, m_odr, m_out, m_evt, m_msk, m_ctl, m_rd;
    logic [31:0] m_h1, m_h2, m_h3;

    function automatic logic [31:0] flip(input logic [31:0] v);
        logic [31:0] r;
        for (int n = 0; n < 32; n++) r[31-n] = v[n];
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h000: return m_dir;
            12'h004: return m_odr;
            12'h008: return (m_out & m_dir) | (m_h2 & ~m_dir);
            12'h00C: return m_evt;
            12'h010: return m_msk;
            12'h014: return m_ctl;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] setv;
        logic [31:0] clrv;
        if (!rst_n) begin
            m_dir = 0; m_odr = 0; m_out = 0; m_evt = 0; m_msk = 0; m_ctl = 0;
            m_rd = 0; m_h1 = 0; m_h2 = 0; m_h3 = 0;
        end else begin
            setv = 0;
            for (int p = 0; p < 32; p++) begin
                if (!m_dir[31-p]) begin
                    if (m_ctl[31-p]) setv[31-p] = (m_h3[31-p] == 1'b1) && (m_h2[31-p] == 1'b0);
                    else             setv[31-p] = (m_h3[31-p] != m_h2[31-p]);
                end
            end
            m_rd = (bus_rd && bus_word) ? m_read(bus_addr) : 32'h0;
            clrv = 0;
            if (bus_wr && bus_word) begin
                case (bus_addr)
                    12'h000: m_dir = bus_wdata;
                    12'h004: m_odr = bus_wdata;
                    12'h008: m_out = bus_wdata;
                    12'h00C: clrv  = bus_wdata;
                    12'h010: m_msk = bus_wdata;
                    12'h014: m_ctl = bus_wdata;
                    default: ;
                endcase
            end
            m_evt = (m_evt & ~clrv) | setv;
            m_h3 = m_h2; m_h2 = m_h1; m_h1 = flip(pin_in);
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got=%08h expected=%08h", tag, got, exp);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            chk("R4 pin_out model", pin_out, flip(m_out & m_dir));
            chk("R4 pin_dir model", pin_dir, flip(m_dir));
            chk("R7 irq model", {31'h0, irq}, {31'h0, |(m_evt & m_msk)});
            chk("R1 rdata model", bus_rdata, m_rd);
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic w);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_word = w; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_word = 1'b1;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic w, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_word = w; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0; bus_word = 1'b1;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        vectors++;
        $display("FAIL watchdog got=%08h expected=%08h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        bus_read(12'h000, 1'b1, rv); chk("R10 direction after reset", rv, 32'h0);
        bus_read(12'h00C, 1'b1, rv); chk("R10 event after reset", rv, 32'h0);
        chk("R10 irq after reset", {31'h0, irq}, 32'h0);
        chk("R10 pin_out after reset", pin_out, 32'h0);

        // R3 R4: pins 0..3 outputs, data A5A5A5A5 -> pins 0,2 high
        bus_write(12'h000, 32'hF000_0000, 1'b1);
        bus_write(12'h008, 32'hA5A5_A5A5, 1'b1);
        chk("R3 pin_out order", pin_out, 32'h0000_0005);
        chk("R4 pin_dir", pin_dir, 32'h0000_000F);
        bus_read(12'h008, 1'b1, rv); chk("R5 data readback outputs only", rv, 32'hA000_0000);

        // R8 R13 R5: pin 31 rises (register bit 0), any-edge mode
        pin_in[31] = 1'b1;
        wait_clk(3);
        bus_read(12'h008, 1'b1, rv); chk("R5 data mixes input sample", rv, 32'hA000_0001);
        bus_read(12'h00C, 1'b1, rv); chk("R8 rising edge event", rv, 32'h0000_0001);
        chk("R7 irq masked off", {31'h0, irq}, 32'h0);
        bus_write(12'h010, 32'h0000_0001, 1'b1);
        chk("R7 irq on mask", {31'h0, irq}, 32'h1);

        // R6: zero write keeps, one write clears
        bus_write(12'h00C, 32'h0000_0000, 1'b1);
        bus_read(12'h00C, 1'b1, rv); chk("R6 zero write keeps", rv, 32'h0000_0001);
        bus_write(12'h00C, 32'h0000_0001, 1'b1);
        bus_read(12'h00C, 1'b1, rv); chk("R6 one write clears", rv, 32'h0);
        chk("R7 irq after clear", {31'h0, irq}, 32'h0);

        // R2: narrow and unmapped accesses
        bus_write(12'h000, 32'hFFFF_FFFF, 1'b0);
        bus_read(12'h000, 1'b1, rv); chk("R2 narrow write ignored", rv, 32'hF000_0000);
        bus_read(12'h000, 1'b0, rv); chk("R2 narrow read zero", rv, 32'h0);
        bus_write(12'h018, 32'hFFFF_FFFF, 1'b1);
        bus_read(12'h018, 1'b1, rv); chk("R2 unmapped read zero", rv, 32'h0);
        chk("R2 unmapped write no pin change", pin_out, 32'h0000_0005);

        // R1 R12: open-drain storage only
        bus_write(12'h004, 32'h1234_5678, 1'b1);
        bus_read(12'h004, 1'b1, rv); chk("R1 open-drain readback", rv, 32'h1234_5678);
        chk("R12 open-drain no pin effect", pin_out, 32'h0000_0005);

        // R9: falling-only on pin 30 (register bit 1)
        bus_write(12'h014, 32'h0000_0002, 1'b1);
        bus_read(12'h014, 1'b1, rv); chk("R1 control readback", rv, 32'h0000_0002);
        bus_write(12'h010, 32'hFFFF_FFFF, 1'b1);
        pin_in[30] = 1'b1;
        wait_clk(4);
        bus_read(12'h00C, 1'b1, rv); chk("R9 rise ignored", rv, 32'h0);
        pin_in[30] = 1'b0;
        wait_clk(4);
        bus_read(12'h00C, 1'b1, rv); chk("R9 fall sets event", rv, 32'h0000_0002);
        chk("R7 irq from fall", {31'h0, irq}, 32'h1);
        bus_write(12'h00C, 32'hFFFF_FFFF, 1'b1);

        // R13: latency of pin 31 falling to irq
        pin_in[31] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R13 no irq after two edges", {31'h0, irq}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R13 irq after third edge", {31'h0, irq}, 32'h1);
        bus_write(12'h00C, 32'hFFFF_FFFF, 1'b1);

        // R4: output pin 0 toggling sets no event
        pin_in[0] = 1'b1;
        wait_clk(4);
        bus_read(12'h00C, 1'b1, rv); chk("R4 output pin no event", rv, 32'h0);

        // R11: set and clear in the same cycle
        pin_in[31] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_addr = 12'h00C; bus_wdata = 32'hFFFF_FFFF; bus_word = 1'b1; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(12'h00C, 1'b1, rv); chk("R11 set beats clear", rv, 32'h0000_0001);

        wait_clk(2);
        finish_run();
    end
endmodule